// File: doc/BRIEF.md
# Bridge Target Retry Decision Unit

This unit sits beside the target side of a bridge and decides, for the initiator cycle now on the bus, whether the bridge must refuse it with a target retry. The cycle is one of three kinds: a delayed write, a delayed read or a posted write. The unit combines the queue, lock, prefetch and buffer-space status supplied by neighbouring logic with a small acceptance timer. Its output is a retry flag and a code that gives the highest-priority reason for the retry.

Most of the decision is combinational. The only state is the acceptance timer. An address-phase strobe starts this timer, and it counts the clocks spent accepting the current delayed transaction. Once more than the allowed number of clocks have passed, the timer forces a retry. A delayed transaction that is retried is later reissued by its initiator with the same address and command. The unit treats each reissue as a new address phase. Discarding stale entries after the master timeout is left to the queue logic.

Top module: `retry_decider`

## Requirements
- R1: `txn_class` encodes 0 = delayed write, 1 = delayed read, 2 = posted write and 3 = no cycle. With class 3, `retry` is 0 and `reason` is 0, whatever the other inputs are.
- R2: When `lock_prop` is 1 and `txn_locked` is 0, every class from 0 to 2 is retried with reason 1. This reason outranks all others.
- R3: A delayed transaction with both `txn_locked` and `tbus_locked` high is retried with reason 2, provided R2 does not apply.
- R4: A delayed transaction is retried with reason 3 when `dq_full` is high. Otherwise it is retried with reason 4 when `dq_dup` is high.
- R5: A delayed transaction is retried with reason 5 while `dq_entering` is high, reason 6 while `dq_waiting` is high, and reason 7 while `dq_not_head` is high, in that order of priority.
- R6: A delayed read is also retried with reason 8 when `pw_ahead` is high and with reason 9 when `pf_discard` is high. A delayed write ignores both inputs.
- R7: A posted write is retried with reason 10 when `pw_free` is below 2, since the buffer needs one entry for the address and one for a data DWORD. With 2 or more free entries it is not retried. The queue, prefetch, bus-lock and timer inputs have no effect on a posted write.
- R8: The timer is loaded with 1 on a clock edge where `addr_phase` is high. After that it advances by one on each edge where `acc_active` is high. When the count exceeds 16, a delayed transaction with no higher reason is retried with reason 11. A new address phase restarts the count.
- R9: When several conditions hold at once, `reason` reports the lowest-numbered applicable code.
- R10: `retry` is 1 exactly when `reason` is nonzero.
- R11: After reset the timer is idle. No timeout is reported until an address phase has occurred, however long `acc_active` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | Address phase of a new cycle; restarts the acceptance count |
| acc_active | input | 1 | Acceptance of the current cycle still in progress |
| txn_class | input | 2 | Cycle kind: 0 delayed write, 1 delayed read, 2 posted write, 3 none |
| dq_entering | input | 1 | Request being written into the delayed queue |
| dq_waiting | input | 1 | Request queued, target response or read data not yet back |
| dq_not_head | input | 1 | Completion present but not yet at the head of its queue |
| dq_full | input | 1 | Delayed queue cannot take another request |
| dq_dup | input | 1 | Request with the same address and command already queued |
| pw_ahead | input | 1 | Posted write ordered ahead of the read completion |
| pf_discard | input | 1 | Earlier prefetched data being flushed |
| lock_prop | input | 1 | Locked sequence currently crossing the bridge |
| tbus_locked | input | 1 | Target-side bus already locked |
| txn_locked | input | 1 | Incoming cycle is part of a locked sequence |
| pw_free | input | 6 | Free entries (DWORDs) in the posted write buffer |
| retry | output | 1 | Answer this cycle with a target retry |
| reason | output | 4 | Highest-priority retry reason code, 0 when none |

## Verification
On every cycle the assertions check the class-independent rules: the idle class stays quiet, an unlocked cycle during lock propagation gets code 1, locked delayed cycles hitting a locked bus get code 2, posted writes only ever report codes 0, 1 or 10 and pass when there is room, the cycle after an address phase never times out, and the flag agrees with the code. Only the bench scenarios can show the full priority ladder among the queue reasons, that read-only reasons are ignored for writes, the exact clock at which the acceptance count crosses 16, and that a fresh address phase clears an expired count.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

  typedef enum logic [1:0] {
    CLS_DWR  = 2'd0,
    CLS_DRD  = 2'd1,
    CLS_PWR  = 2'd2,
    CLS_IDLE = 2'd3
  } txn_cls_e;

  localparam int NUM_RSN = 12;
  localparam int RSN_W   = $clog2(NUM_RSN);

  typedef enum logic [RSN_W-1:0] {
    RSN_NONE        = 4'd0,
    RSN_LOCK_PROP   = 4'd1,
    RSN_BUS_LOCKED  = 4'd2,
    RSN_Q_FULL      = 4'd3,
    RSN_DUP         = 4'd4,
    RSN_ENTERING    = 4'd5,
    RSN_WAITING     = 4'd6,
    RSN_NOT_HEAD    = 4'd7,
    RSN_PW_AHEAD    = 4'd8,
    RSN_DISCARD     = 4'd9,
    RSN_PW_SPACE    = 4'd10,
    RSN_ACC_TIMEOUT = 4'd11
  } rsn_e;

  // Which reasons may fire for each class; bit index equals reason code.
  function automatic logic [NUM_RSN-1:0] class_mask(txn_cls_e c);
    logic [NUM_RSN-1:0] m;
    m = '0;
    case (c)
      CLS_DWR: begin
        m[RSN_LOCK_PROP]   = 1'b1;
        m[RSN_BUS_LOCKED]  = 1'b1;
        m[RSN_Q_FULL]      = 1'b1;
        m[RSN_DUP]         = 1'b1;
        m[RSN_ENTERING]    = 1'b1;
        m[RSN_WAITING]     = 1'b1;
        m[RSN_NOT_HEAD]    = 1'b1;
        m[RSN_ACC_TIMEOUT] = 1'b1;
      end
      CLS_DRD: begin
        m[RSN_LOCK_PROP]   = 1'b1;
        m[RSN_BUS_LOCKED]  = 1'b1;
        m[RSN_Q_FULL]      = 1'b1;
        m[RSN_DUP]         = 1'b1;
        m[RSN_ENTERING]    = 1'b1;
        m[RSN_WAITING]     = 1'b1;
        m[RSN_NOT_HEAD]    = 1'b1;
        m[RSN_PW_AHEAD]    = 1'b1;
        m[RSN_DISCARD]     = 1'b1;
        m[RSN_ACC_TIMEOUT] = 1'b1;
      end
      CLS_PWR: begin
        m[RSN_LOCK_PROP]   = 1'b1;
        m[RSN_PW_SPACE]    = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rtd_accept_timer.sv
module rtd_accept_timer #(
  parameter int ACC_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_phase,
  input  logic acc_active,
  output logic expired
);
  localparam int CNT_W = $clog2(ACC_LIMIT + 2);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(ACC_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Idle at zero until the first address phase; saturates past the limit.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (addr_phase) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (acc_active && (cnt_q != '0) && (cnt_q != SAT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == SAT);

endmodule

// File: rtl/rtd_cond.sv
module rtd_cond
  import rtd_pkg::*;
#(
  parameter int FREE_W = 6,
  parameter int PW_MIN = 2
) (
  input  txn_cls_e            cls,
  input  logic                dq_entering,
  input  logic                dq_waiting,
  input  logic                dq_not_head,
  input  logic                dq_full,
  input  logic                dq_dup,
  input  logic                pw_ahead,
  input  logic                pf_discard,
  input  logic                lock_prop,
  input  logic                tbus_locked,
  input  logic                txn_locked,
  input  logic [FREE_W-1:0]   pw_free,
  input  logic                acc_expired,
  output logic [NUM_RSN-1:0]  hits
);
  logic [NUM_RSN-1:0] raw;

  always_comb begin
    raw                  = '0;
    raw[RSN_LOCK_PROP]   = lock_prop & ~txn_locked;
    raw[RSN_BUS_LOCKED]  = txn_locked & tbus_locked;
    raw[RSN_Q_FULL]      = dq_full;
    raw[RSN_DUP]         = dq_dup;
    raw[RSN_ENTERING]    = dq_entering;
    raw[RSN_WAITING]     = dq_waiting;
    raw[RSN_NOT_HEAD]    = dq_not_head;
    raw[RSN_PW_AHEAD]    = pw_ahead;
    raw[RSN_DISCARD]     = pf_discard;
    raw[RSN_PW_SPACE]    = (pw_free < FREE_W'(PW_MIN));
    raw[RSN_ACC_TIMEOUT] = acc_expired;
  end

  assign hits = raw & class_mask(cls);

endmodule

// File: rtl/rtd_prio.sv
module rtd_prio #(
  parameter int N = 12,
  parameter int W = 4
) (
  input  logic [N-1:0] hits,
  output logic         any,
  output logic [W-1:0] code
);
  // Lowest nonzero index wins; index 0 is the "no reason" slot.
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (hits[i]) code = W'(i);
    end
  end

  assign any = |hits[N-1:1];

endmodule

// File: rtl/retry_decider.sv
module retry_decider
  import rtd_pkg::*;
#(
  parameter int FREE_W    = 6,
  parameter int PW_MIN    = 2,
  parameter int ACC_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic              acc_active,
  input  logic [1:0]        txn_class,
  input  logic              dq_entering,
  input  logic              dq_waiting,
  input  logic              dq_not_head,
  input  logic              dq_full,
  input  logic              dq_dup,
  input  logic              pw_ahead,
  input  logic              pf_discard,
  input  logic              lock_prop,
  input  logic              tbus_locked,
  input  logic              txn_locked,
  input  logic [FREE_W-1:0] pw_free,
  output logic              retry,
  output logic [RSN_W-1:0]  reason
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               acc_expired;
  logic [NUM_RSN-1:0] hits;
  txn_cls_e           cls;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cls = txn_cls_e'(txn_class);

  rtd_accept_timer #(.ACC_LIMIT(ACC_LIMIT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .addr_phase (addr_phase),
    .acc_active (acc_active),
    .expired    (acc_expired)
  );

  rtd_cond #(.FREE_W(FREE_W), .PW_MIN(PW_MIN)) u_cond (
    .cls         (cls),
    .dq_entering (dq_entering),
    .dq_waiting  (dq_waiting),
    .dq_not_head (dq_not_head),
    .dq_full     (dq_full),
    .dq_dup      (dq_dup),
    .pw_ahead    (pw_ahead),
    .pf_discard  (pf_discard),
    .lock_prop   (lock_prop),
    .tbus_locked (tbus_locked),
    .txn_locked  (txn_locked),
    .pw_free     (pw_free),
    .acc_expired (acc_expired),
    .hits        (hits)
  );

  rtd_prio #(.N(NUM_RSN), .W(RSN_W)) u_prio (
    .hits (hits),
    .any  (retry),
    .code (reason)
  );

endmodule

// File: rtl/retry_decider_chk.sv
module retry_decider_chk #(
  parameter int FREE_W = 6,
  parameter int PW_MIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_phase,
  input logic [1:0]        txn_class,
  input logic              lock_prop,
  input logic              tbus_locked,
  input logic              txn_locked,
  input logic [FREE_W-1:0] pw_free,
  input logic              retry,
  input logic [3:0]        reason
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_class == 2'd3) |-> (!retry && reason == 4'd0)); // R1

  AST_LOCK_PROP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_class != 2'd3 && lock_prop && !txn_locked) |-> (retry && reason == 4'd1)); // R2

  AST_BUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_class < 2'd2 && txn_locked && tbus_locked) |-> (reason == 4'd2)); // R3

  AST_PW_REASONS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_class == 2'd2) |-> (reason == 4'd0 || reason == 4'd1 || reason == 4'd10)); // R7

  AST_PW_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_class == 2'd2 && !(lock_prop && !txn_locked) && pw_free >= FREE_W'(PW_MIN))
      |-> !retry); // R7

  AST_NO_TIMEOUT_AFTER_AP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> (reason != 4'd11)); // R8

  AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    retry == (reason != 4'd0)); // R10
endmodule

bind retry_decider retry_decider_chk #(.FREE_W(FREE_W), .PW_MIN(PW_MIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_phase  (addr_phase),
  .txn_class   (txn_class),
  .lock_prop   (lock_prop),
  .tbus_locked (tbus_locked),
  .txn_locked  (txn_locked),
  .pw_free     (pw_free),
  .retry       (retry),
  .reason      (reason)
);

// File: tb/retry_decider_test.sv
module retry_decider_test;
  localparam int FREE_W = 6;

  // flag bit positions for the drive task
  localparam int F_ENT = 0, F_WAIT = 1, F_HEAD = 2, F_FULL = 3, F_DUP = 4;
  localparam int F_AHEAD = 5, F_DISC = 6, F_LPROP = 7, F_BLOCK = 8, F_TLOCK = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic addr_phase, acc_active;
  logic [1:0] txn_class;
  logic dq_entering, dq_waiting, dq_not_head, dq_full, dq_dup;
  logic pw_ahead, pf_discard, lock_prop, tbus_locked, txn_locked;
  logic [FREE_W-1:0] pw_free;
  logic retry;
  logic [3:0] reason;

  int checks = 0, fails = 0;
  int elapsed = 0;
  bit done = 1'b0;

  typedef struct { int rsn; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  retry_decider uut (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .acc_active(acc_active),
    .txn_class(txn_class), .dq_entering(dq_entering), .dq_waiting(dq_waiting),
    .dq_not_head(dq_not_head), .dq_full(dq_full), .dq_dup(dq_dup),
    .pw_ahead(pw_ahead), .pf_discard(pf_discard), .lock_prop(lock_prop),
    .tbus_locked(tbus_locked), .txn_locked(txn_locked), .pw_free(pw_free),
    .retry(retry), .reason(reason)
  );

  // Bench view of the acceptance count (R8, R11)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      elapsed <= 0;
    else if (addr_phase)                             elapsed <= 1;
    else if (acc_active && elapsed != 0 && elapsed <= 16) elapsed <= elapsed + 1;
  end

  function automatic int model(input logic [1:0] c, input logic [9:0] f, input int free, input int el);
    if (c == 2'd3) return 0;
    if (f[F_LPROP] && !f[F_TLOCK]) return 1;
    if (c == 2'd2) return (free < 2) ? 10 : 0;
    if (f[F_TLOCK] && f[F_BLOCK]) return 2;
    if (f[F_FULL])  return 3;
    if (f[F_DUP])   return 4;
    if (f[F_ENT])   return 5;
    if (f[F_WAIT])  return 6;
    if (f[F_HEAD])  return 7;
    if (c == 2'd1 && f[F_AHEAD]) return 8;
    if (c == 2'd1 && f[F_DISC])  return 9;
    if (el > 16) return 11;
    return 0;
  endfunction

  task automatic drive(input logic [1:0] c, input logic [9:0] f, input int free,
                       input logic ap, input logic act, input string tag);
    exp_t e;
    @(negedge clk);
    txn_class = c; addr_phase = ap; acc_active = act; pw_free = FREE_W'(free);
    dq_entering = f[F_ENT]; dq_waiting = f[F_WAIT]; dq_not_head = f[F_HEAD];
    dq_full = f[F_FULL]; dq_dup = f[F_DUP]; pw_ahead = f[F_AHEAD];
    pf_discard = f[F_DISC]; lock_prop = f[F_LPROP]; tbus_locked = f[F_BLOCK];
    txn_locked = f[F_TLOCK];
    e.rsn = model(c, f, free, elapsed);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: samples mid low phase, after the driver has settled inputs
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (reason !== 4'(e.rsn) || retry !== (e.rsn != 0)) begin
          fails++;
          $display("FAIL %s: got retry=%0b reason=%0d, expected retry=%0b reason=%0d",
                   e.tag, retry, reason, (e.rsn != 0), e.rsn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    txn_class = 2'd3; addr_phase = 0; acc_active = 0; pw_free = '0;
    dq_entering = 0; dq_waiting = 0; dq_not_head = 0; dq_full = 0; dq_dup = 0;
    pw_ahead = 0; pf_discard = 0; lock_prop = 0; tbus_locked = 0; txn_locked = 0;
    repeat (3) @(posedge clk);
    drive(2'd0, 10'h000, 8, 0, 0, "R11 reset state delayed write");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 idle class ignores everything
    drive(2'd3, 10'h3FF, 0, 0, 0, "R1 idle with all flags");
    // R2 lock propagation, each class
    drive(2'd0, 10'h080, 8, 0, 0, "R2 lock prop delayed write");
    drive(2'd1, 10'h0FF, 8, 0, 0, "R2 lock prop beats queue reasons");
    drive(2'd2, 10'h080, 0, 0, 0, "R2 lock prop beats posted space");
    drive(2'd1, 10'h280, 8, 0, 0, "R2 locked cycle escapes lock prop");
    // R3 locked cycle on locked bus
    drive(2'd0, 10'h31F, 8, 0, 0, "R3 bus locked over queue reasons");
    drive(2'd2, 10'h300, 8, 0, 0, "R3 R7 bus lock ignored for posted");
    // R4 / R5 / R9 priority ladder
    drive(2'd0, 10'h018, 8, 0, 0, "R4 R9 full over dup");
    drive(2'd1, 10'h010, 8, 0, 0, "R4 dup match");
    drive(2'd0, 10'h007, 8, 0, 0, "R5 R9 entering first");
    drive(2'd0, 10'h006, 8, 0, 0, "R5 waiting");
    drive(2'd1, 10'h004, 8, 0, 0, "R5 not at head");
    // R6 read-only reasons
    drive(2'd1, 10'h060, 8, 0, 0, "R6 R9 posted ahead over discard");
    drive(2'd1, 10'h040, 8, 0, 0, "R6 discard");
    drive(2'd0, 10'h060, 8, 0, 0, "R6 write ignores read reasons");
    // R7 posted buffer space boundary
    drive(2'd2, 10'h000, 0, 0, 0, "R7 posted no space");
    drive(2'd2, 10'h000, 1, 0, 0, "R7 posted one entry");
    drive(2'd2, 10'h000, 2, 0, 0, "R7 posted two entries");
    drive(2'd2, 10'h07F, 63, 0, 0, "R7 posted ignores queue flags");
    drive(2'd0, 10'h000, 8, 0, 0, "R10 clean delayed write no retry");

    // R11 long activity without an address phase never times out
    for (int i = 0; i < 20; i++) drive(2'd0, 10'h000, 8, 0, 1, "R11 no timeout before address phase");

    // R8 acceptance timer
    drive(2'd0, 10'h000, 8, 1, 1, "R8 address phase");
    for (int i = 0; i < 17; i++) drive(2'd0, 10'h000, 8, 0, 1, "R8 acceptance count");
    drive(2'd1, 10'h000, 8, 0, 1, "R8 timeout on delayed read");
    drive(2'd1, 10'h002, 8, 0, 1, "R8 R9 waiting outranks timeout");
    drive(2'd2, 10'h000, 8, 0, 1, "R7 R8 posted ignores timeout");
    drive(2'd0, 10'h000, 8, 1, 1, "R8 new address phase while expired");
    drive(2'd0, 10'h000, 8, 0, 0, "R8 count restarted");
    drive(2'd0, 10'h000, 8, 0, 0, "R8 count held while inactive");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule